// File: doc/BRIEF.md
# Refresh Interval Timer for an SDRAM Controller

This block tells an SDRAM controller when a refresh is due. A three-bit rate code picks one of five intervals, each double the one before, from 15.6 us to 249.6 us. The block counts controller clock cycles and fires each time the chosen interval ends. Every firing adds one to a count of owed refreshes. The request output stays high for as long as that count is above zero. Each acknowledge from the controller settles one owed refresh.

The interval timer runs freely. It does not wait for the acknowledge, so a slow controller builds up a backlog instead of losing refreshes. The backlog stops growing at a parameterised ceiling. The block is idle while the enable input is low, while the rate code is 000, and while the code is one of the two reserved values. This lets firmware keep refresh off until memory initialisation has finished. The number of cycles in each interval comes from a clock-frequency parameter in MHz.

Top module: `rfsh_timer`

## Requirements
- R1: After reset, `refresh_req` is 0 and `pending_cnt` is 0.
- R2: While `refresh_en` is 0, or `rate_code` is 3'b000, the timer is idle. No request is raised, and `pending_cnt` is cleared at the next rising edge.
- R3: Rate codes 3'b110 and 3'b111 behave exactly like 3'b000.
- R4: With the configuration held steady, the timer expires once every L cycles. The first expiry is counted at the (L+1)-th rising edge after `refresh_en` or `rate_code` last changed. L = (156 × 2^(code−1) × CLK_MHZ) / 10.
- R5: The rate code sets L as follows: 001 gives 15.6 us, 010 gives 31.2 us, 011 gives 62.4 us, 100 gives 124.8 us and 101 gives 249.6 us.
- R6: `refresh_req` is high exactly while `pending_cnt` is non-zero. When `refresh_ack` is high at a rising edge and no expiry happens at that edge, `pending_cnt` drops by one.
- R7: An expiry with no acknowledge at the same edge raises `pending_cnt` by one. The count saturates at PEND_MAX (default 8).
- R8: When an expiry and an acknowledge fall on the same edge and the count is non-zero, `pending_cnt` does not change.
- R9: An acknowledge while `pending_cnt` is 0 has no effect on the count or on the interval timing.
- R10: A change of `rate_code` restarts the interval from zero and keeps the owed count.
- R11: Taking `refresh_en` low clears the owed count at the next edge, and `refresh_req` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_en | input | 1 | Enables refresh timing once memory initialisation is done |
| rate_code | input | 3 | Interval select: 0 off, 1..5 are 15.6..249.6 us, 6 and 7 off |
| refresh_ack | input | 1 | Controller has issued one refresh |
| refresh_req | output | 1 | At least one refresh is owed |
| pending_cnt | output | $clog2(PEND_MAX+1) | Number of owed refreshes |

## Verification
On every cycle, the assertions check how the owed count moves: it goes up on an unacknowledged expiry, down on an acknowledge, holds on a collision, and never passes its ceiling. They also check that the count is cleared and no request is raised while the timer is idle or the code is reserved, and that a configuration change sends the timer back to zero. The absolute length of each interval, the fact that timing survives a stray acknowledge, and the restart point after a code change can only be seen in the bench. Its scenarios count exact edge numbers from the moment the configuration changes.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  localparam int unsigned BASE_TENTHS_US = 156;
  localparam logic [2:0]  LONGEST_CODE   = 3'd5;

  function automatic logic code_is_valid(input logic [2:0] code);
    return (code >= 3'd1) && (code <= LONGEST_CODE);
  endfunction

  function automatic int unsigned interval_cycles(input logic [2:0] code,
                                                  input int unsigned clk_mhz);
    int unsigned sh;
    if (!code_is_valid(code)) return 0;
    sh = 32'(code) - 1;
    return ((BASE_TENTHS_US << sh) * clk_mhz) / 10;
  endfunction

endpackage

// File: rtl/rfsh_interval_sel.sv
module rfsh_interval_sel
  import rfsh_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned TW      = 16
) (
  input  logic          enable,
  input  logic [2:0]    code,
  output logic          active,
  output logic [TW-1:0] limit
);

  always_comb begin
    active = enable && code_is_valid(code);
    limit  = TW'(interval_cycles(code, CLK_MHZ));
  end

endmodule

// File: rtl/rfsh_tick_counter.sv
module rfsh_tick_counter #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [TW-1:0] limit,
  output logic          expire,
  output logic [TW-1:0] tick
);

  assign expire = !reload && (tick == limit - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                tick <= '0;
    else if (reload || expire) tick <= '0;
    else                       tick <= tick + TW'(1);
  end

endmodule

// File: rtl/rfsh_pending_ctr.sv
module rfsh_pending_ctr #(
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned PW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          expire,
  input  logic          ack,
  output logic [PW-1:0] count
);

  logic inc, dec;

  always_comb begin
    inc = expire;
    dec = ack && (count != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      count <= '0;
    end else if (inc && !dec) begin
      if (count != PW'(PEND_MAX)) count <= count + PW'(1);
    end else if (dec && !inc) begin
      count <= count - PW'(1);
    end
  end

endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer
  import rfsh_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned PEND_MAX = 8,
  localparam int unsigned TW = $clog2(interval_cycles(LONGEST_CODE, CLK_MHZ) + 1),
  localparam int unsigned PW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          refresh_en,
  input  logic [2:0]    rate_code,
  input  logic          refresh_ack,
  output logic          refresh_req,
  output logic [PW-1:0] pending_cnt
);

  logic          active_w;
  logic [TW-1:0] limit_w;
  logic          reload_w;
  logic          expire_w;
  logic [TW-1:0] tick_w;
  logic [3:0]    cfg_q;

  rfsh_interval_sel #(.CLK_MHZ(CLK_MHZ), .TW(TW)) u_sel (
    .enable (refresh_en),
    .code   (rate_code),
    .active (active_w),
    .limit  (limit_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= {refresh_en, rate_code};
  end

  assign reload_w = !active_w || (cfg_q != {refresh_en, rate_code});

  rfsh_tick_counter #(.TW(TW)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (reload_w),
    .limit  (limit_w),
    .expire (expire_w),
    .tick   (tick_w)
  );

  rfsh_pending_ctr #(.PEND_MAX(PEND_MAX), .PW(PW)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active_w),
    .expire (expire_w),
    .ack    (refresh_ack),
    .count  (pending_cnt)
  );

  assign refresh_req = (pending_cnt != '0);

endmodule

// File: rtl/rfsh_timer_chk.sv
module rfsh_timer_chk #(
  parameter int unsigned PEND_MAX = 8,
  parameter int unsigned PW       = 4,
  parameter int unsigned TW       = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          refresh_en,
  input logic [2:0]    rate_code,
  input logic          refresh_ack,
  input logic          refresh_req,
  input logic [PW-1:0] pending_cnt,
  input logic          active,
  input logic          reload,
  input logic          expire,
  input logic [TW-1:0] tick
);

  p_idle_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_en |=> (pending_cnt == '0) && !refresh_req);

  p_reserved_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == 3'd0 || rate_code == 3'd6 || rate_code == 3'd7) |=> !refresh_req);

  p_expire_needs_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> active);

  p_ack_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && refresh_ack && pending_cnt != '0 && !expire)
      |=> pending_cnt == $past(pending_cnt) - PW'(1));

  p_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !refresh_ack && pending_cnt != PW'(PEND_MAX))
      |=> pending_cnt == $past(pending_cnt) + PW'(1));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pending_cnt <= PW'(PEND_MAX));

  p_collide_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && expire && refresh_ack && pending_cnt != '0) |=> $stable(pending_cnt));

  p_ack_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && refresh_ack && pending_cnt == '0 && !expire) |=> pending_cnt == '0);

  p_reload_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> tick == '0);

endmodule

bind rfsh_timer rfsh_timer_chk #(.PEND_MAX(PEND_MAX), .PW(PW), .TW(TW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .refresh_en  (refresh_en),
  .rate_code   (rate_code),
  .refresh_ack (refresh_ack),
  .refresh_req (refresh_req),
  .pending_cnt (pending_cnt),
  .active      (active_w),
  .reload      (reload_w),
  .expire      (expire_w),
  .tick        (tick_w)
);

// File: tb/sim_rfsh_timer.sv
module sim_rfsh_timer;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PERIOD = 10;
  localparam int MHZ        = 10;
  localparam int PMAX       = 8;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       refresh_en = 0;
  logic [2:0] rate_code = 0;
  logic       refresh_ack = 0;
  logic       refresh_req;
  logic [3:0] pending_cnt;

  int checks = 0, fails = 0, req_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfsh_timer #(.CLK_MHZ(MHZ), .PEND_MAX(PMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .refresh_en(refresh_en), .rate_code(rate_code),
    .refresh_ack(refresh_ack), .refresh_req(refresh_req), .pending_cnt(pending_cnt)
  );

  always @(negedge clk) if (refresh_req) req_seen++;

  // Interval length restated from the requirement: 15.6 us doubled per code step.
  function automatic int exp_len(input int code);
    int tenths;
    case (code)
      1: tenths = 156;  2: tenths = 312;  3: tenths = 624;
      4: tenths = 1248; 5: tenths = 2496; default: tenths = 0;
    endcase
    return tenths * MHZ / 10;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int act, input int expv, input string tag);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic cfg(input bit en, input int code);
    refresh_en = 0;
    cyc(1);
    refresh_en = en;
    rate_code  = 3'(code);
  endtask

  task automatic ack_n(input int n);
    refresh_ack = 1;
    cyc(n);
    refresh_ack = 0;
  endtask

  task automatic t_reset_r1;
    cyc(3);
    chk(refresh_req, 0, "R1 req in reset");
    rst_n = 1;
    cyc(2);
    chk(refresh_req, 0, "R1 req after reset");
    chk(pending_cnt, 0, "R1 pending after reset");
  endtask

  task automatic t_codes_r5;
    for (int c = 1; c <= 5; c++) begin
      cfg(1, c);
      cyc(exp_len(c));
      chk(pending_cnt, 0, $sformatf("R5 code %0d before expiry", c));
      cyc(1);
      chk(pending_cnt, 1, $sformatf("R5 R4 code %0d first expiry", c));
      chk(refresh_req, 1, $sformatf("R6 code %0d req high", c));
    end
  endtask

  task automatic t_ack_r6_r9;
    int l = exp_len(1);
    cfg(1, 1);
    ack_n(1);
    chk(pending_cnt, 0, "R9 ack on empty");
    cyc(l - 1);
    chk(pending_cnt, 0, "R9 timing unaffected, before expiry");
    cyc(1);
    chk(pending_cnt, 1, "R9 timing unaffected, expiry");
    ack_n(1);
    chk(pending_cnt, 0, "R6 ack decrements");
    chk(refresh_req, 0, "R6 req drops");
    cyc(l - 2);
    chk(pending_cnt, 0, "R4 period, before second expiry");
    cyc(1);
    chk(pending_cnt, 1, "R4 period, second expiry");
  endtask

  task automatic t_sat_r7_r8;
    int l = exp_len(1);
    cfg(1, 1);
    cyc(l + 1 + 7 * l);
    chk(pending_cnt, 8, "R7 eight expiries");
    cyc(l);
    chk(pending_cnt, 8, "R7 saturated");
    ack_n(3);
    chk(pending_cnt, 5, "R6 three acks");
    cyc(l - 4);
    chk(pending_cnt, 5, "R8 before collision");
    ack_n(1);
    chk(pending_cnt, 5, "R8 expiry and ack same edge");
    cyc(1);
    chk(pending_cnt, 5, "R8 steady after collision");
  endtask

  task automatic t_rate_change_r10_r11;
    int l1 = exp_len(1), l2 = exp_len(2);
    cfg(1, 1);
    cyc(l1 + 1);
    chk(pending_cnt, 1, "R10 setup");
    cyc(50);
    rate_code = 3'd2;
    cyc(1);
    chk(pending_cnt, 1, "R10 count kept on code change");
    cyc(l2 - 1);
    chk(pending_cnt, 1, "R10 no expiry before new interval");
    cyc(1);
    chk(pending_cnt, 2, "R10 expiry after restart");
    refresh_en = 0;
    cyc(1);
    chk(pending_cnt, 0, "R11 disable clears count");
    chk(refresh_req, 0, "R11 req falls");
  endtask

  task automatic t_idle_r2;
    req_seen = 0;
    cyc(3000);
    chk(req_seen, 0, "R2 enable low, no request");
    cfg(1, 0);
    req_seen = 0;
    cyc(3000);
    chk(req_seen, 0, "R2 code 000, no request");
    chk(pending_cnt, 0, "R2 code 000 count");
  endtask

  task automatic t_reserved_r3;
    for (int c = 6; c <= 7; c++) begin
      cfg(1, c);
      req_seen = 0;
      cyc(2700);
      chk(req_seen, 0, $sformatf("R3 code %0d no request", c));
    end
    cfg(1, 1);
    cyc(exp_len(1) + 1);
    chk(pending_cnt, 1, "R3 R2 valid code after reserved");
  endtask

  initial begin
    t_reset_r1();
    t_codes_r5();
    t_ack_r6_r9();
    t_sat_r7_r8();
    t_rate_change_r10_r11();
    t_idle_r2();
    t_reserved_r3();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule